// File: doc/BRIEF.md
# I2C Register-Read Target with CRC

This block is an I2C target that answers register reads. The host first writes a one-byte register pointer. It then reads one or more bytes from that pointer, either after a repeated start or after a stop and a fresh start. Returned data come from a synchronous read port that the surrounding logic serves. The pointer advances after every data byte, so a block read walks through consecutive registers.

An optional CRC-8 byte can follow every data byte. The polynomial is 0x07, the initial value is 0x00, and bits are folded in MSB first in the order they appear on the wire. The first checksum of a read spans every byte since the opening start, including the bytes before a repeated start. Each later checksum spans only its own data byte. A stop clears the accumulator. A NACK from the host on a checksum byte makes the target give up the transfer.

SCL and SDA arrive already synchronized to the system clock. SDA is driven through an active-high pull-down enable.

Top module: `i2c_crc_read_target`

## Requirements
- R1: A start condition (SDA falling while SCL is high), whether a first start or a repeated one, restarts address reception with a cleared bit count in any state. A stop condition (SDA rising while SCL is high) returns the target to idle with SDA released.
- R2: The first byte after a start carries the 7-bit device address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). On a match the target pulls SDA low for the acknowledge bit. On a mismatch it leaves SDA released until the next start.
- R3: After an address byte with the write direction, the next byte is acknowledged and loaded as the register pointer.
- R4: After an address byte with the read direction, the target returns the register at the pointer, MSB first. It fetches that register with a one-cycle `reg_rd_en` pulse; `reg_rd_data` is valid on the following clock.
- R5: The pointer increments by one (modulo 256) after each data byte, so consecutive data bytes come from consecutive registers. A read with no preceding pointer write continues from the current pointer.
- R6: With `crc_en` = 0, only data bytes are sent. A host ACK (SDA low) requests the next byte. A host NACK (SDA high) ends the transfer and SDA stays released.
- R7: With `crc_en` = 1, each data byte is followed by a CRC-8 byte. The polynomial is 0x07, the initial value is 0x00, and bits are taken MSB first in wire order. Acknowledge bits are not included.
- R8: The checksum for the first data byte covers every byte since the first start, repeated start included: address+write, register pointer, address+read, then the data byte.
- R9: The accumulator clears after each data byte's checksum and on every stop. Later checksums cover only their own data byte. After a stop-then-start, the first checksum covers address+read and the data byte.
- R10: A host NACK on a checksum byte sends the target to idle, and SDA stays released for any further clocks.
- R11: `sda_oe` changes only while SCL is low, and is released during every acknowledge bit that the host drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| crc_en | input | 1 | 1 appends a CRC-8 byte after each data byte |
| reg_rd_en | output | 1 | One-cycle register fetch strobe |
| reg_rd_addr | output | 8 | Register being fetched (current pointer) |
| reg_rd_data | input | 8 | Register value, valid the clock after the strobe |

## Verification
A wrong bit count, state or pointer shows up on `sda_oe`. If the target is out of step with the host, the target drives, or fails to drive, SDA during an SCL high phase. The reference model compares that level on every clock of that same high phase, so the error is caught within the bit in which it happens. A wrong checksum or a skipped pointer increment shows at the latest by the end of the affected byte, through the byte the host assembles.

// File: rtl/i2c_crd_pkg.sv
package i2c_crd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } crd_state_e;

  // One wire bit folded into an MSB-first CRC register.
  function automatic logic [7:0] crc_bit_step(input logic [7:0] cur,
                                              input logic       wire_bit,
                                              input logic [7:0] poly);
    logic fb;
    fb = cur[7] ^ wire_bit;
    return {cur[6:0], 1'b0} ^ (fb ? poly : 8'h00);
  endfunction

endpackage

// File: rtl/i2c_crd_linemon.sv
module i2c_crd_linemon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_crd_crc8.sv
module i2c_crd_crc8 #(
  parameter logic [7:0] POLY = 8'h07,
  parameter logic [7:0] INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  logic       bit_in,
  output logic [7:0] crc
);
  import i2c_crd_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= INIT;
    else if (clr)  crc <= INIT;
    else if (step) crc <= crc_bit_step(crc, bit_in, POLY);
  end
endmodule

// File: rtl/i2c_crc_read_target.sv
module i2c_crc_read_target #(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter logic [7:0] CRC_POLY = 8'h07,
  parameter logic [7:0] CRC_INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       crc_en,
  output logic       reg_rd_en,
  output logic [7:0] reg_rd_addr,
  input  logic [7:0] reg_rd_data
);
  import i2c_crd_pkg::*;

  localparam int              CNT_W    = 4;
  localparam logic [CNT_W-1:0] BYTE_LEN = CNT_W'(8);

  crd_state_e       state, ack_nxt;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       rx_sh, tx_sh, ptr, nxt_data, crc_hold;
  logic             is_crc, mst_ack, fetch_q, fetch_d1;

  // named internal events
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic       byte_done, addr_hit, data_done, crc_clr, crc_step, crc_in;
  logic [7:0] crc_val;

  i2c_crd_linemon u_mon (
    .clk(clk), .rst_n(rst_n), .scl(scl_i), .sda(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_done = scl_fall && (bit_cnt == BYTE_LEN);
  assign addr_hit  = (rx_sh[7:1] == DEV_ADDR);
  assign data_done = byte_done && (state == ST_TX) && !is_crc;
  assign crc_clr   = stop_det || data_done;
  assign crc_step  = scl_rise && ((state == ST_ADDR) || (state == ST_REG) ||
                                  ((state == ST_TX) && !is_crc));
  assign crc_in    = (state == ST_TX) ? tx_sh[7] : sda_i;

  i2c_crd_crc8 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .step(crc_step),
    .bit_in(crc_in), .crc(crc_val)
  );

  assign reg_rd_en   = fetch_q;
  assign reg_rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ack_nxt  <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      ptr      <= '0;
      nxt_data <= '0;
      crc_hold <= '0;
      is_crc   <= 1'b0;
      mst_ack  <= 1'b0;
      fetch_q  <= 1'b0;
      fetch_d1 <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      fetch_q  <= 1'b0;
      fetch_d1 <= fetch_q;
      if (fetch_d1) nxt_data <= reg_rd_data;

      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_REG: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[6:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_done) begin
              bit_cnt <= '0;
              if (state == ST_REG) begin
                ptr     <= rx_sh;
                sda_oe  <= 1'b1;
                state   <= ST_ACK;
                ack_nxt <= ST_IDLE;
              end else if (addr_hit) begin
                sda_oe  <= 1'b1;
                state   <= ST_ACK;
                ack_nxt <= rx_sh[0] ? ST_TX : ST_REG;
                fetch_q <= rx_sh[0];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state   <= ack_nxt;
              bit_cnt <= '0;
              is_crc  <= 1'b0;
              if (ack_nxt == ST_TX) begin
                tx_sh  <= nxt_data;
                sda_oe <= ~nxt_data[7];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_done) begin
              sda_oe  <= 1'b0;
              state   <= ST_TXACK;
              bit_cnt <= '0;
              if (!is_crc) begin
                crc_hold <= crc_val;
                ptr      <= ptr + 8'd1;
                fetch_q  <= 1'b1;
              end
            end else if (scl_fall) begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mst_ack <= ~sda_i;
            end else if (scl_fall) begin
              bit_cnt <= '0;
              if (!mst_ack) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
              end else if (!is_crc && crc_en) begin
                is_crc <= 1'b1;
                tx_sh  <= crc_hold;
                sda_oe <= ~crc_hold[7];
                state  <= ST_TX;
              end else begin
                is_crc <= 1'b0;
                tx_sh  <= nxt_data;
                sda_oe <= ~nxt_data[7];
                state  <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  assert_oe_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  assert_release_host_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TXACK) |-> !sda_oe);

  assert_fetch_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);

  assert_stop_goes_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe));

  assert_start_clears_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR && bit_cnt == '0));

  assert_stop_clears_crc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (crc_val == CRC_INIT));

  assert_ptr_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_done |=> (ptr == $past(ptr) + 8'd1));

  assert_crc_nack_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TXACK && is_crc && scl_fall && !mst_ack && !start_det && !stop_det)
      |=> (state == ST_IDLE && !sda_oe));

endmodule

// File: tb/tb_i2c_crc_read_target.sv
`timescale 1ns/1ps
module tb_i2c_crc_read_target;
  localparam logic [6:0] DEV = 7'h2C;
  localparam logic [7:0] AW  = {DEV, 1'b0};
  localparam logic [7:0] AR  = {DEV, 1'b1};
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sdam = 1'b1, crc_on = 1'b0;
  logic sda_oe, reg_rd_en;
  logic [7:0] reg_rd_addr, reg_rd_data;
  wire sda_line = sdam & ~sda_oe;

  int errors = 0, checks = 0, cyc = 0;
  int exp_mode = 2;            // 0 released, 1 driven, 2 don't care
  string cur_req = "R11";
  logic [7:0] mptr = 8'h00;

  always #10 clk = ~clk;

  i2c_crc_read_target #(.DEV_ADDR(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .crc_en(crc_on), .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data)
  );

  function automatic logic [7:0] regval(input logic [7:0] a);
    return a * 8'd37 + 8'h5C;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) reg_rd_data <= 8'h00;
    else if (reg_rd_en) reg_rd_data <= regval(reg_rd_addr);
  end

  // byte-wise CRC-8, poly 0x07
  function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock reference comparison while SCL is high
  always @(negedge clk) begin
    #2;
    if (rst_n && scl && exp_mode != 2)
      chk(sda_oe == exp_mode[0], cur_req, "sda_oe during SCL high", sda_oe, exp_mode);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "R1", "watchdog cycles", cyc, 150000);
      report();
      $finish;
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    exp_mode = 0; sdam = 1'b1; wait_clks(H);
    scl = 1'b1; wait_clks(H);
    sdam = 1'b0; wait_clks(H);
    scl = 1'b0; exp_mode = 2; wait_clks(H);
  endtask

  task automatic bus_stop();
    exp_mode = 2; scl = 1'b0; sdam = 1'b0; wait_clks(H);
    exp_mode = 0; scl = 1'b1; wait_clks(H);
    sdam = 1'b1; wait_clks(H);
  endtask

  task automatic clk_bit(input logic mbit, input int expm, output logic seen);
    sdam = mbit; exp_mode = 2; wait_clks(H);
    exp_mode = expm; scl = 1'b1; wait_clks(H);
    seen = sda_line;
    scl = 1'b0; exp_mode = 2;
  endtask

  task automatic write_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic s;
    cur_req = req;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], 0, s);
    clk_bit(1'b1, exp_ack ? 1 : 0, s);
    chk(!s == exp_ack, req, "target ack", !s, exp_ack);
  endtask

  task automatic read_byte(input logic [7:0] exp, input bit mack, input string req);
    logic s;
    logic [7:0] got;
    cur_req = req;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, exp[i] ? 0 : 1, s);
      got[i] = s;
    end
    cur_req = "R11";
    clk_bit(!mack, 0, s);
    chk(got == exp, req, "read byte", got, exp);
  endtask

  // mode 0: repeated start, 1: stop then start, 2: no pointer write
  task automatic xfer(input logic [7:0] ra, input int n, input int mode);
    logic [7:0] c, d;
    c = 8'h00;
    if (mode != 2) begin
      bus_start();
      write_byte(AW, 1, "R2"); c = crc_upd(c, AW);
      write_byte(ra, 1, "R3"); c = crc_upd(c, ra); mptr = ra;
      if (mode == 1) begin bus_stop(); c = 8'h00; end
    end
    bus_start();
    write_byte(AR, 1, "R2"); c = crc_upd(c, AR);
    for (int i = 0; i < n; i++) begin
      d = regval(mptr); mptr = mptr + 8'd1;
      c = crc_upd(c, d);
      read_byte(d, crc_on ? 1'b1 : (i < n - 1), (i == 0) ? "R4" : "R5");
      if (crc_on) begin
        read_byte(c, i < n - 1, (i == 0 && mode == 0) ? "R8" : (i == 0 ? "R9" : "R7"));
        c = 8'h00;
      end
    end
  endtask

  initial begin
    logic s;
    wait_clks(5);
    chk(sda_oe == 1'b0, "R11", "reset sda_oe", sda_oe, 0);
    chk(reg_rd_en == 1'b0, "R4", "reset reg_rd_en", reg_rd_en, 0);
    rst_n = 1'b1;
    wait_clks(4);

    // R4 R6: single read, no CRC, repeated start
    crc_on = 1'b0;
    xfer(8'h10, 1, 0); bus_stop();

    // R5 R6: block read wrapping the pointer, then extra clocks stay released
    xfer(8'hFE, 3, 0);
    read_byte(8'hFF, 1'b0, "R6");
    bus_stop();

    // R2: address mismatch leaves SDA released
    bus_start();
    write_byte({7'h2D, 1'b0}, 0, "R2");
    write_byte(8'h00, 0, "R2");
    bus_stop();

    // R7 R8: CRC single read, host NACKs the CRC byte
    crc_on = 1'b1;
    xfer(8'h33, 1, 0); bus_stop();

    // R7 R9 R5: CRC block read, later CRCs cover data only
    xfer(8'h80, 3, 0); bus_stop();

    // R9: stop between pointer write and read phase
    xfer(8'h40, 1, 1); bus_stop();

    // R5: read without pointer write continues from pointer
    xfer(8'h00, 1, 2); bus_stop();

    // R10: NACK on first CRC of a block, further clocks see SDA released
    xfer(8'h20, 1, 0);
    read_byte(8'hFF, 1'b0, "R10");
    bus_stop();

    // R1: start in the middle of a byte restarts reception
    crc_on = 1'b0;
    bus_start();
    cur_req = "R1";
    clk_bit(1'b0, 0, s);
    clk_bit(1'b1, 0, s);
    clk_bit(1'b0, 0, s);
    bus_start();
    write_byte(AR, 1, "R1");
    read_byte(regval(mptr), 1'b0, "R1");
    mptr = mptr + 8'd1;
    bus_stop();
    chk(sda_oe == 1'b0, "R1", "released after stop", sda_oe, 0);

    wait_clks(4);
    report();
    $finish;
  end
endmodule